// File: doc/BRIEF.md
# Four-Channel DMA Register Front End

This block is the processor-side register file of a four-channel DMA controller that sits on an 8-bit I/O bus. A four-bit port address selects one of sixteen byte-wide ports. The first eight ports reach the per-channel 16-bit address and count registers. The remaining eight carry the shared controls: command and status, request, single-channel mask, mode, pointer clear, master reset, mask clear and multi-channel mask. A shared byte pointer orders the two byte accesses that each 16-bit register needs, low byte first and high byte second.

The block exports each channel's start address, count, mode fields and mask bit to a separate transfer engine. It also exports a global disable flag and a per-channel ready vector, which combines the live request lines with the masks and the disable flag. Terminal-count pulses from the engine are latched until software reads status. Bus-master transfers, cascading and memory-to-memory copies are not part of this block.

Top module: `dmac_regfile`

## Requirements
- R1: Channel n's address register is reached at port 2n and its count register at port 2n+1. The shared ports follow at 8 through 15 in this order: command write / status read (8), request (9), single mask (10), mode (11), pointer clear (12), master reset (13), mask clear (14), multi mask (15).
- R2: Every read or write of ports 0–7 uses the current byte pointer (0 = bits [7:0], 1 = bits [15:8]) and then flips the pointer. Any write to port 12 returns the pointer to the low byte. `base_addr_o` and `count_o` show the stored 16-bit values, with channel n in slice [16n+15:16n].
- R3: A write to port 10 sets channel wdata[1:0]'s mask bit to wdata[2] (1 = masked). The other mask bits are left unchanged.
- R4: A write to port 15 loads mask bit n from wdata[n] for n = 0..3. Any write to port 14 clears all four mask bits.
- R5: A write to port 11 stores wdata[7:2] as the mode of channel wdata[1:0]. The `mode_o` slice [6n+5:6n] holds, for channel n: the transfer kind at [1:0] (0 verify, 1 to memory, 2 from memory), auto-initialise at [2], decrement at [3] and the operating mode at [5:4] (0 demand, 1 single, 2 block, 3 cascade).
- R6: A write to port 8 sets `ctrl_off_o` to wdata[2]. `ready_o[n]` equals req_in[n] AND NOT mask[n] AND NOT `ctrl_off_o`.
- R7: A write to port 13 returns the pointer to the low byte, clears the latched terminal-count flags and sets all four mask bits. Address, count and mode registers keep their values.
- R8: A read of port 8 returns the latched terminal-count flags in [3:0] and the live `req_in` in [7:4], then clears the latched flags. A `tc_pulse` bit that arrives in the same cycle as the read stays latched.
- R9: A `tc_pulse` bit sets its latched flag. The flag stays set until a status read or a master reset.
- R10: Reads of ports 9–15 return 0. A write to port 9 changes no state. `rdata` is 0 whenever `cs` or `rd_en` is low.
- R11: After synchronous reset, all address, count and mode values, the pointer, the latched flags and the disable flag are 0, and all masks are set.
- R12: A read of port 2n or 2n+1 returns the byte of the channel n address or count register that the pointer selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Port access select |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 4 | Port number |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational during the read cycle |
| tc_pulse | input | 4 | Terminal-count pulses from the transfer engine |
| req_in | input | 4 | Live DMA request lines |
| base_addr_o | output | 64 | Per-channel 16-bit start address |
| count_o | output | 64 | Per-channel 16-bit count |
| mode_o | output | 24 | Per-channel 6-bit mode fields |
| mask_o | output | 4 | Per-channel mask bits |
| ctrl_off_o | output | 1 | Controller disabled |
| ready_o | output | 4 | Unmasked, enabled requests |

## Verification
The hardest situation to reach from the ports is a terminal-count pulse that lands in the same cycle as a status read. The read must report the old flags while the new flag survives the clear. A directed step drives that pulse during the read strobe and reads status twice in a row. The byte pointer is a second hard case, because it is hidden state shared by all eight channel ports. The random phase interleaves channel-port reads and writes with pointer clears and master resets across channels, so a pointer left odd by one channel governs the next channel's access.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int NCH     = 4;
    localparam int DW      = 8;
    localparam int RW      = 2 * DW;
    localparam int AW      = 4;
    localparam int CSEL_W  = $clog2(NCH);
    localparam int MODE_W  = 6;

    localparam logic [AW-1:0] OFS_CMD   = AW'(2 * NCH);
    localparam logic [AW-1:0] OFS_REQ   = AW'(2 * NCH + 1);
    localparam logic [AW-1:0] OFS_SMASK = AW'(2 * NCH + 2);
    localparam logic [AW-1:0] OFS_MODE  = AW'(2 * NCH + 3);
    localparam logic [AW-1:0] OFS_FFCLR = AW'(2 * NCH + 4);
    localparam logic [AW-1:0] OFS_MRST  = AW'(2 * NCH + 5);
    localparam logic [AW-1:0] OFS_MCLR  = AW'(2 * NCH + 6);
    localparam logic [AW-1:0] OFS_MMASK = AW'(2 * NCH + 7);

    typedef enum logic [1:0] {
        XFER_VERIFY   = 2'd0,
        XFER_TO_MEM   = 2'd1,
        XFER_FROM_MEM = 2'd2,
        XFER_RSVD     = 2'd3
    } xfer_e;

    typedef enum logic [1:0] {
        OP_DEMAND  = 2'd0,
        OP_SINGLE  = 2'd1,
        OP_BLOCK   = 2'd2,
        OP_CASCADE = 2'd3
    } op_e;

    // Packed so that it lines up with write-data bits [7:2] of the mode port.
    typedef struct packed {
        op_e   op;
        logic  dec;
        logic  autoinit;
        xfer_e xfer;
    } chmode_t;

    typedef enum logic [3:0] {
        P_CHAN, P_CMD, P_REQ, P_SMASK, P_MODE,
        P_FFCLR, P_MRST, P_MCLR, P_MMASK, P_NONE
    } port_e;

    function automatic port_e port_kind(input logic [AW-1:0] a);
        port_e k;
        case (a)
            OFS_CMD:   k = P_CMD;
            OFS_REQ:   k = P_REQ;
            OFS_SMASK: k = P_SMASK;
            OFS_MODE:  k = P_MODE;
            OFS_FFCLR: k = P_FFCLR;
            OFS_MRST:  k = P_MRST;
            OFS_MCLR:  k = P_MCLR;
            OFS_MMASK: k = P_MMASK;
            default:   k = (a < OFS_CMD) ? P_CHAN : P_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_addr,
    input  logic          wr_cnt,
    input  logic          hi,
    input  logic [DW-1:0] wdata,
    input  logic          mode_wr,
    input  chmode_t       mode_in,
    output logic [RW-1:0] addr_o,
    output logic [RW-1:0] cnt_o,
    output chmode_t       mode_o
);

    logic [RW-1:0] addr_q, cnt_q;
    chmode_t       mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
            mode_q <= '0;
        end else begin
            if (wr_addr) begin
                if (hi) addr_q[RW-1:DW] <= wdata;
                else    addr_q[DW-1:0]  <= wdata;
            end
            if (wr_cnt) begin
                if (hi) cnt_q[RW-1:DW] <= wdata;
                else    cnt_q[DW-1:0]  <= wdata;
            end
            if (mode_wr) mode_q <= mode_in;
        end
    end

    assign addr_o = addr_q;
    assign cnt_o  = cnt_q;
    assign mode_o = mode_q;

    assert_lo_byte_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_addr && !hi) |=> (addr_q[DW-1:0] == $past(wdata))
                           && (addr_q[RW-1:DW] == $past(addr_q[RW-1:DW])));

    assert_hi_byte_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_cnt && hi) |=> (cnt_q[RW-1:DW] == $past(wdata))
                         && (cnt_q[DW-1:0] == $past(cnt_q[DW-1:0])));

    assert_mode_load_R5: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> mode_q == $past(mode_in));

    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !mode_wr |=> $stable(mode_q));

endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
    import dmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ff_clr,
    input  logic             ff_step,
    input  logic             mreset,
    input  logic             mask_clr,
    input  logic             smask_wr,
    input  logic             mmask_wr,
    input  logic             cmd_wr,
    input  logic             stat_rd,
    input  logic [NCH-1:0]   wbits,
    input  logic [NCH-1:0]   tc_pulse,
    input  logic [NCH-1:0]   req_in,
    output logic             ff_hi,
    output logic [NCH-1:0]   mask_o,
    output logic             off_o,
    output logic [2*NCH-1:0] status_o
);

    logic           ff_q, off_q;
    logic [NCH-1:0] mask_q, tc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ff_q   <= 1'b0;
            mask_q <= '1;
            tc_q   <= '0;
            off_q  <= 1'b0;
        end else begin
            if (mreset || ff_clr) ff_q <= 1'b0;
            else if (ff_step)     ff_q <= ~ff_q;

            if (mreset)        mask_q <= '1;
            else if (mask_clr) mask_q <= '0;
            else if (mmask_wr) mask_q <= wbits;
            else if (smask_wr) mask_q[wbits[CSEL_W-1:0]] <= wbits[2];

            if (mreset) tc_q <= '0;
            else        tc_q <= (stat_rd ? '0 : tc_q) | tc_pulse;

            if (cmd_wr) off_q <= wbits[2];
        end
    end

    assign ff_hi    = ff_q;
    assign mask_o   = mask_q;
    assign off_o    = off_q;
    assign status_o = {req_in, tc_q};

    assert_ff_clear_R2: assert property (@(posedge clk) disable iff (rst)
        ff_clr |=> !ff_q);

    assert_ff_flip_R2: assert property (@(posedge clk) disable iff (rst)
        (ff_step && !ff_clr && !mreset) |=> ff_q != $past(ff_q));

    assert_mreset_R7: assert property (@(posedge clk) disable iff (rst)
        mreset |=> (mask_q == '1) && (tc_q == '0) && !ff_q);

    assert_single_mask_R3: assert property (@(posedge clk) disable iff (rst)
        (smask_wr && !mreset && !mask_clr && !mmask_wr)
            |=> mask_q[$past(wbits[CSEL_W-1:0])] == $past(wbits[2]));

    assert_tc_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (!stat_rd && !mreset) |=> (tc_q & $past(tc_q)) == $past(tc_q));

    assert_status_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !mreset) |=> (tc_q & ~$past(tc_pulse)) == '0);

endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
    import dmac_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cs,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    input  logic [NCH-1:0]      tc_pulse,
    input  logic [NCH-1:0]      req_in,
    output logic [NCH*RW-1:0]   base_addr_o,
    output logic [NCH*RW-1:0]   count_o,
    output logic [NCH*MODE_W-1:0] mode_o,
    output logic [NCH-1:0]      mask_o,
    output logic                ctrl_off_o,
    output logic [NCH-1:0]      ready_o
);

    port_e             kind;
    logic              wr_acc, rd_acc;
    logic [CSEL_W-1:0] ch_idx;
    logic              ff_hi;
    logic [NCH-1:0]    mask_w;
    logic              off_w;
    logic [2*NCH-1:0]  status_w;
    logic [RW-1:0]     ch_addr [NCH];
    logic [RW-1:0]     ch_cnt  [NCH];
    chmode_t           ch_mode [NCH];
    logic [RW-1:0]     sel_word;

    assign kind   = port_kind(addr);
    assign wr_acc = cs && wr_en;
    assign rd_acc = cs && rd_en;
    assign ch_idx = addr[CSEL_W:1];

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            logic hit;
            assign hit = (kind == P_CHAN) && (ch_idx == CSEL_W'(i));
            dmac_chan u_chan (
                .clk     (clk),
                .rst     (rst),
                .wr_addr (wr_acc && hit && !addr[0]),
                .wr_cnt  (wr_acc && hit && addr[0]),
                .hi      (ff_hi),
                .wdata   (wdata),
                .mode_wr (wr_acc && (kind == P_MODE)
                          && (wdata[CSEL_W-1:0] == CSEL_W'(i))),
                .mode_in (chmode_t'(wdata[DW-1:2])),
                .addr_o  (ch_addr[i]),
                .cnt_o   (ch_cnt[i]),
                .mode_o  (ch_mode[i])
            );
            assign base_addr_o[i*RW +: RW]     = ch_addr[i];
            assign count_o[i*RW +: RW]         = ch_cnt[i];
            assign mode_o[i*MODE_W +: MODE_W]  = ch_mode[i];
        end
    endgenerate

    dmac_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ff_clr   (wr_acc && (kind == P_FFCLR)),
        .ff_step  ((wr_acc || rd_acc) && (kind == P_CHAN)),
        .mreset   (wr_acc && (kind == P_MRST)),
        .mask_clr (wr_acc && (kind == P_MCLR)),
        .smask_wr (wr_acc && (kind == P_SMASK)),
        .mmask_wr (wr_acc && (kind == P_MMASK)),
        .cmd_wr   (wr_acc && (kind == P_CMD)),
        .stat_rd  (rd_acc && (kind == P_CMD)),
        .wbits    (wdata[NCH-1:0]),
        .tc_pulse (tc_pulse),
        .req_in   (req_in),
        .ff_hi    (ff_hi),
        .mask_o   (mask_w),
        .off_o    (off_w),
        .status_o (status_w)
    );

    assign sel_word = addr[0] ? ch_cnt[ch_idx] : ch_addr[ch_idx];

    always_comb begin
        rdata = '0;
        if (rd_acc) begin
            case (kind)
                P_CHAN:  rdata = ff_hi ? sel_word[RW-1:DW] : sel_word[DW-1:0];
                P_CMD:   rdata = status_w;
                default: rdata = '0;
            endcase
        end
    end

    assign mask_o     = mask_w;
    assign ctrl_off_o = off_w;
    assign ready_o    = req_in & ~mask_w & {NCH{~off_w}};

    assert_disable_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && (kind == P_CMD) && wdata[2]) |=> (ready_o == '0));

    assert_req_port_inert_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && (kind == P_REQ)) |=> $stable(mask_o) && $stable(ctrl_off_o));

    assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_acc |-> (rdata == '0));

endmodule

// File: tb/sim_dmac_regfile.sv
module sim_dmac_regfile;
    import dmac_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, cs, wr_en, rd_en;
    logic [3:0]  addr, tc_pulse, req_in, mask_o, ready_o;
    logic [7:0]  wdata, rdata;
    logic [63:0] base_addr_o, count_o;
    logic [23:0] mode_o;
    logic        ctrl_off_o;

    dmac_regfile u0 (.*);

    int  n_run = 0, n_fail = 0;
    bit  done = 1'b0;

    logic [15:0] m_addr [4];
    logic [15:0] m_cnt  [4];
    logic [5:0]  m_mode [4];
    logic [3:0]  m_mask, m_tc;
    logic        m_ff, m_off;

    task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(int p);
        logic [15:0] w;
        if (p < 8) begin
            w = p[0] ? m_cnt[p/2] : m_addr[p/2];
            return m_ff ? w[15:8] : w[7:0];
        end
        if (p == 8) return {req_in, m_tc};
        return 8'h00;
    endfunction

    function automatic string rd_tag(int p);
        if (p < 8)  return "R12";
        if (p == 8) return "R8";
        return "R10";
    endfunction

    task automatic check_outs();
        logic [63:0] ea, ec;
        logic [23:0] em;
        for (int i = 0; i < 4; i++) begin
            ea[i*16 +: 16] = m_addr[i];
            ec[i*16 +: 16] = m_cnt[i];
            em[i*6 +: 6]   = m_mode[i];
        end
        chk("R2", "base_addr_o", base_addr_o, ea);
        chk("R2", "count_o", count_o, ec);
        chk("R5", "mode_o", mode_o, em);
        chk("R3", "mask_o", mask_o, m_mask);
        chk("R6", "ctrl_off_o", ctrl_off_o, m_off);
        chk("R6", "ready_o", ready_o, req_in & ~m_mask & {4{~m_off}});
    endtask

    task automatic model_wr(int p, logic [7:0] d);
        if (p < 8) begin
            if (p[0]) begin
                if (m_ff) m_cnt[p/2][15:8] = d; else m_cnt[p/2][7:0] = d;
            end else begin
                if (m_ff) m_addr[p/2][15:8] = d; else m_addr[p/2][7:0] = d;
            end
            m_ff = ~m_ff;
        end else begin
            case (p)
                8:  m_off = d[2];
                10: m_mask[d[1:0]] = d[2];
                11: m_mode[d[1:0]] = d[7:2];
                12: m_ff = 1'b0;
                13: begin m_ff = 1'b0; m_tc = '0; m_mask = 4'hF; end
                14: m_mask = '0;
                15: m_mask = d[3:0];
                default: ;
            endcase
        end
    endtask

    task automatic bus_wr(int p, logic [7:0] d);
        @(negedge clk);
        cs = 1; wr_en = 1; addr = p[3:0]; wdata = d;
        @(posedge clk); #1;
        cs = 0; wr_en = 0;
        model_wr(p, d);
        check_outs();
    endtask

    task automatic bus_rd(int p);
        @(negedge clk);
        cs = 1; rd_en = 1; addr = p[3:0];
        #1 chk(rd_tag(p), "rdata", rdata, exp_rd(p));
        @(posedge clk); #1;
        cs = 0; rd_en = 0;
        if (p < 8) m_ff = ~m_ff;
        if (p == 8) m_tc = '0;
        check_outs();
    endtask

    task automatic pulse_tc(logic [3:0] v);
        @(negedge clk); tc_pulse = v;
        @(posedge clk); #1 tc_pulse = '0;
        m_tc = m_tc | v;
    endtask

    task automatic set_req(logic [3:0] v);
        @(negedge clk); req_in = v;
        #1 check_outs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5EED_0042));
        rst = 1; cs = 0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
        tc_pulse = '0; req_in = '0;
        for (int i = 0; i < 4; i++) begin m_addr[i] = '0; m_cnt[i] = '0; m_mode[i] = '0; end
        m_mask = 4'hF; m_tc = '0; m_ff = 0; m_off = 0;
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk("R11", "mask after reset", mask_o, 4'hF);
        chk("R11", "base after reset", base_addr_o, 64'h0);
        chk("R11", "mode after reset", mode_o, 24'h0);
        chk("R11", "off after reset", ctrl_off_o, 1'b0);
        @(negedge clk); rst = 0;
        bus_rd(8);      // R11: status zero
        bus_rd(0);      // R11: pointer low

        // R1: channel 2 count lives at port 5
        bus_wr(12, 8'h00);
        bus_wr(5, 8'h34);
        bus_wr(5, 8'h12);
        chk("R1", "count ch2", count_o[47:32], 16'h1234);
        chk("R1", "base ch2 untouched", base_addr_o[47:32], 16'h0000);

        // R2/R12: ordered readback, pointer clear mid-sequence
        bus_wr(6, 8'hCD); bus_wr(6, 8'hAB);
        bus_rd(6); bus_rd(6);
        bus_rd(6);            // pointer now high
        bus_wr(12, 8'h77);    // R2: clear to low
        bus_rd(7);            // low byte of ch3 count

        // R3/R4: masks
        bus_wr(14, 8'h00);
        chk("R4", "mask clear", mask_o, 4'h0);
        bus_wr(10, 8'b0000_0110);
        chk("R3", "single mask set ch2", mask_o, 4'h4);
        bus_wr(10, 8'b0000_0010);
        chk("R3", "single mask clear ch2", mask_o, 4'h0);
        bus_wr(15, 8'hFA);
        chk("R4", "multi mask", mask_o, 4'hA);

        // R5: mode fields, block + decrement + auto + to-memory on ch1
        bus_wr(11, {2'd2, 1'b1, 1'b1, 2'd1, 2'd1});
        chk("R5", "mode ch1", mode_o[11:6], 6'b10_1_1_01);

        // R6: disable gates ready
        set_req(4'hF);
        chk("R6", "ready enabled", ready_o, 4'h5);
        bus_wr(8, 8'h04);
        chk("R6", "ready disabled", ready_o, 4'h0);
        bus_wr(8, 8'h00);

        // R9/R8: latch, status read, coincident pulse
        pulse_tc(4'b0011);
        bus_wr(0, 8'h11);         // unrelated traffic keeps flag (R9)
        bus_rd(8);
        bus_rd(8);                // R8: cleared by previous read
        pulse_tc(4'b1000);
        @(negedge clk);
        cs = 1; rd_en = 1; addr = 4'd8; tc_pulse = 4'b0100;
        #1 chk("R8", "status with coincident tc", rdata, {req_in, 4'b1000});
        @(posedge clk); #1;
        cs = 0; rd_en = 0; tc_pulse = '0;
        m_tc = 4'b0100;
        bus_rd(8);                // R8: coincident pulse survived

        // R7: master reset
        pulse_tc(4'b1111);
        bus_wr(14, 8'h00);
        bus_wr(2, 8'h5A);         // pointer high
        bus_wr(13, 8'h00);
        chk("R7", "mask after master reset", mask_o, 4'hF);
        bus_rd(2);                // R7: pointer back to low, value kept
        bus_wr(12, 8'h00);
        bus_rd(8);                // R7: flags cleared

        // R10: request port inert, unused ports read zero
        pulse_tc(4'b0001);
        bus_wr(9, 8'hFF);
        bus_rd(8);
        for (int p = 9; p < 16; p++) bus_rd(p);

        // Random mix
        for (int it = 0; it < 600; it++) begin
            int r;
            r = $urandom_range(0, 9);
            d = 8'($urandom);
            case (r)
                0, 1, 2, 3: bus_wr($urandom_range(0, 7), d);
                4:          bus_rd($urandom_range(0, 7));
                5:          bus_rd(8);
                6:          bus_wr($urandom_range(8, 15), d);
                7:          pulse_tc(4'($urandom));
                8:          set_req(4'($urandom));
                default:    bus_rd($urandom_range(9, 15));
            endcase
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule